// File: doc/BRIEF.md
# Seconds Alarm Flag Generator

This block watches a free-running seconds count and raises an alarm flag when the count reaches a programmed value. The seconds counter lives outside the block. It supplies its current value and a one-cycle strobe in each cycle where it advances. The stored alarm value is compared with the supplied seconds value only in a strobe cycle. A match in that cycle sets the flag on the next clock edge.

The flag is sticky. It has no clear bit of its own and no mask. The only way to clear it is to write a new alarm value, and every write clears it. Writing a value below the current time keeps the flag from setting again while time moves forward, which disarms the alarm. An interrupt enable input gates only the interrupt request. The flag itself keeps working whatever the enable is set to.

Top module: `seconds_alarm`

## Requirements
- R1: After a synchronous reset the stored alarm value reads back as 0, the flag is low and the interrupt request is low.
- R2: When `sec_tick` is high and no alarm write occurs, the flag goes high on the next clock edge if `sec_value` equals the stored alarm value. If the two differ, the flag keeps its previous state.
- R3: When `sec_tick` is low, the flag does not set, even if `sec_value` equals the stored alarm value.
- R4: Once set, the flag stays high through later cycles, with or without strobes, until an alarm write occurs.
- R5: A cycle with `alm_wr` high leaves the flag low after the next edge. This holds even when the same cycle also has a strobe whose `sec_value` matches the old stored value, so the write takes priority.
- R6: A cycle with `alm_wr` high stores `alm_wdata`, and `alm_rdata` shows the new value from the next edge onward. The full 32-bit range is supported, including all-ones.
- R7: `irq` is a combinational level equal to the flag AND `irq_en`. The enable has no effect on whether the flag sets or clears.
- R8: After an alarm value below the current seconds value is written, further strobes with increasing `sec_value` leave the flag low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_value | input | 32 | Current seconds count |
| sec_tick | input | 1 | High for one cycle when the seconds count advances |
| alm_wr | input | 1 | Alarm register write strobe |
| alm_wdata | input | 32 | Alarm value to store |
| irq_en | input | 1 | Interrupt enable |
| alarm_flag | output | 1 | Sticky alarm flag |
| alm_rdata | output | 32 | Stored alarm value |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default 32-bit time width. This brings the all-ones alarm value and a matching all-ones seconds value within reach, which checks that the comparator uses every bit. The vector table drives the following cases in sequence:
- a mismatch strobe;
- a match without a strobe;
- a true match;
- stickiness while the enable is toggled;
- a write that coincides with a matching strobe;
- a disarming write of a value in the past.

Directed steps then cover the reset state and a reset that arrives while the flag is set.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

    localparam int unsigned TIME_W_DEF = 32;

    typedef enum logic [1:0] {
        FL_HOLD  = 2'd0,
        FL_SET   = 2'd1,
        FL_CLEAR = 2'd2
    } flag_act_e;

    typedef struct packed {
        logic wr;
        logic tick;
        logic hit;
    } flag_evt_t;

    function automatic flag_act_e decide_act(input flag_evt_t ev);
        if (ev.wr)
            return FL_CLEAR;
        else if (ev.tick && ev.hit)
            return FL_SET;
        else
            return FL_HOLD;
    endfunction

endpackage

// File: rtl/alarm_value_reg.sv
module alarm_value_reg #(
    parameter int unsigned TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [TIME_W-1:0] wdata,
    output logic [TIME_W-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst)
            value <= '0;
        else if (wr)
            value <= wdata;
    end

    // R6: a write is visible on the readback one edge later
    p_wr_loads_r6: assert property (@(posedge clk) disable iff (rst)
        wr |=> value == $past(wdata));

    // R6: without a write the stored value does not move
    p_value_held_r6: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(value));
endmodule

// File: rtl/alarm_flag_ctl.sv
module alarm_flag_ctl
    import alarm_pkg::*;
#(
    parameter int unsigned TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              tick,
    input  logic [TIME_W-1:0] sec_value,
    input  logic [TIME_W-1:0] alarm_value,
    output logic              flag
);
    flag_evt_t evt;
    flag_act_e act;

    always_comb begin
        evt.wr   = wr;
        evt.tick = tick;
        evt.hit  = (sec_value == alarm_value);
        act      = decide_act(evt);
    end

    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else begin
            unique case (act)
                FL_SET:   flag <= 1'b1;
                FL_CLEAR: flag <= 1'b0;
                default:  flag <= flag;
            endcase
        end
    end

    // R2: a strobe on a matching count sets the flag
    p_match_sets_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr && sec_value == alarm_value) |=> flag);

    // R3: without a strobe a low flag stays low
    p_no_tick_no_set_r3: assert property (@(posedge clk) disable iff (rst)
        (!flag && !tick) |=> !flag);

    // R4: the flag is sticky until a write
    p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (flag && !wr) |=> flag);

    // R5: a write always leaves the flag clear
    p_wr_clears_r5: assert property (@(posedge clk) disable iff (rst)
        wr |=> !flag);
endmodule

// File: rtl/seconds_alarm.sv
module seconds_alarm
    import alarm_pkg::*;
#(
    parameter int unsigned TIME_W = TIME_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TIME_W-1:0] sec_value,
    input  logic              sec_tick,
    input  logic              alm_wr,
    input  logic [TIME_W-1:0] alm_wdata,
    input  logic              irq_en,
    output logic              alarm_flag,
    output logic [TIME_W-1:0] alm_rdata,
    output logic              irq
);
    logic [TIME_W-1:0] stored;
    logic              flag_q;

    alarm_value_reg #(.TIME_W(TIME_W)) u_value (
        .clk   (clk),
        .rst   (rst),
        .wr    (alm_wr),
        .wdata (alm_wdata),
        .value (stored)
    );

    alarm_flag_ctl #(.TIME_W(TIME_W)) u_flag (
        .clk         (clk),
        .rst         (rst),
        .wr          (alm_wr),
        .tick        (sec_tick),
        .sec_value   (sec_value),
        .alarm_value (stored),
        .flag        (flag_q)
    );

    assign alarm_flag = flag_q;
    assign alm_rdata  = stored;
    assign irq        = flag_q & irq_en;

    // R7: the request never appears while disabled or without the flag
    p_irq_gated_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> (alarm_flag && irq_en));

    // R1: state leaving reset is clear
    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) |-> (!alarm_flag && alm_rdata == '0));
endmodule

// File: tb/seconds_alarm_test.sv
module seconds_alarm_test;
    localparam int W = 32;

    typedef struct packed {
        logic         wr;
        logic [W-1:0] wdata;
        logic         tick;
        logic [W-1:0] sec;
        logic         en;
        logic         exp_flag;
        logic [W-1:0] exp_rdata;
        logic [7:0]   req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 32'd100,        1'b0, 32'd98,         1'b0, 1'b0, 32'd100,        8'd6}, // R6 load
        '{1'b0, 32'd0,          1'b1, 32'd99,         1'b1, 1'b0, 32'd100,        8'd2}, // R2 mismatch
        '{1'b0, 32'd0,          1'b0, 32'd100,        1'b1, 1'b0, 32'd100,        8'd3}, // R3 no strobe
        '{1'b0, 32'd0,          1'b1, 32'd100,        1'b1, 1'b1, 32'd100,        8'd2}, // R2 match
        '{1'b0, 32'd0,          1'b1, 32'd101,        1'b0, 1'b1, 32'd100,        8'd4}, // R4 sticky, R7 disabled
        '{1'b0, 32'd0,          1'b0, 32'd101,        1'b1, 1'b1, 32'd100,        8'd7}, // R7 enabled
        '{1'b1, 32'd200,        1'b1, 32'd101,        1'b1, 1'b0, 32'd200,        8'd5}, // R5 clear
        '{1'b0, 32'd0,          1'b1, 32'd200,        1'b0, 1'b1, 32'd200,        8'd7}, // R7 flag sets while disabled
        '{1'b1, 32'd200,        1'b1, 32'd200,        1'b1, 1'b0, 32'd200,        8'd5}, // R5 priority
        '{1'b0, 32'd0,          1'b1, 32'd200,        1'b1, 1'b1, 32'd200,        8'd2}, // R2 rearmed
        '{1'b1, 32'd5,          1'b0, 32'd201,        1'b1, 1'b0, 32'd5,          8'd8}, // R8 disarm write
        '{1'b0, 32'd0,          1'b1, 32'd201,        1'b1, 1'b0, 32'd5,          8'd8}, // R8
        '{1'b0, 32'd0,          1'b1, 32'd202,        1'b1, 1'b0, 32'd5,          8'd8}, // R8
        '{1'b1, 32'hFFFF_FFFF,  1'b0, 32'd203,        1'b1, 1'b0, 32'hFFFF_FFFF,  8'd6}, // R6 all-ones
        '{1'b0, 32'd0,          1'b1, 32'hFFFF_FFFF,  1'b1, 1'b1, 32'hFFFF_FFFF,  8'd2}  // R2 full width
    };

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] sec_value;
    logic         sec_tick;
    logic         alm_wr;
    logic [W-1:0] alm_wdata;
    logic         irq_en;
    logic         alarm_flag;
    logic [W-1:0] alm_rdata;
    logic         irq;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    seconds_alarm #(.TIME_W(W)) uut (
        .clk       (clk),
        .rst       (rst),
        .sec_value (sec_value),
        .sec_tick  (sec_tick),
        .alm_wr    (alm_wr),
        .alm_wdata (alm_wdata),
        .irq_en    (irq_en),
        .alarm_flag(alarm_flag),
        .alm_rdata (alm_rdata),
        .irq       (irq)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic wr, input logic [W-1:0] wd, input logic tk,
                         input logic [W-1:0] sv, input logic en);
        alm_wr = wr; alm_wdata = wd; sec_tick = tk; sec_value = sv; irq_en = en;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        drive(1'b0, '0, 1'b0, '0, 1'b1);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 flag", {31'b0, alarm_flag}, 0);
        check("R1 rdata", alm_rdata, 0);
        check("R1 irq", {31'b0, irq}, 0);
        // R3: equal to the reset alarm value of 0 but no strobe
        drive(1'b0, '0, 1'b0, '0, 1'b1);
        @(negedge clk);
        check("R3 zero no strobe", {31'b0, alarm_flag}, 0);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].wr, VECS[i].wdata, VECS[i].tick, VECS[i].sec, VECS[i].en);
            @(negedge clk);
            check($sformatf("R%0d flag v%0d", VECS[i].req, i), {31'b0, alarm_flag}, {31'b0, VECS[i].exp_flag});
            check($sformatf("R%0d rdata v%0d", VECS[i].req, i), alm_rdata, VECS[i].exp_rdata);
            check($sformatf("R7 irq v%0d", i), {31'b0, irq}, {31'b0, VECS[i].exp_flag & VECS[i].en});
        end

        // R7: irq follows enable combinationally while the flag is held
        drive(1'b0, '0, 1'b0, '0, 1'b0);
        #1;
        check("R7 irq off", {31'b0, irq}, 0);
        irq_en = 1'b1;
        #1;
        check("R7 irq on", {31'b0, irq}, 1);
        @(negedge clk);

        // R1: reset while the flag is set
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 flag after reset", {31'b0, alarm_flag}, 0);
        check("R1 rdata after reset", alm_rdata, 0);
        check("R1 irq after reset", {31'b0, irq}, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule